// File: doc/BRIEF.md
# Chained double-buffer DMA channel

This block is one DMA channel that moves 32-bit words between memory and a single device, in either direction. Software programs a current buffer as a pair of byte pointers (a running word pointer and an end pointer) and may also load a second buffer as a further pointer pair. Each word that memory accepts moves the running pointer on by four bytes. When the running pointer reaches the end pointer, the channel either stops or, if chaining is allowed, takes the second pair as its new current buffer in the same cycle, so the data stream carries on without a gap. Before either outcome it copies the four pointers it just finished with into a read-only saved bank, so software can find where a transfer ended and restart it after an interruption.

Control goes through a command/status register. A write never loads the status directly. Its individual command bits set the enable, set single-update mode, pick the direction, clear the completion flag, reset the channel, or empty the internal one-word buffer. A read returns the five status flags. An interrupt line stays high while the completion flag or the bus-exception flag is set. An error response from memory stops the channel and leaves every pointer where it was.

The memory side and both device sides are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. Once the channel raises `mem_req_valid` or `dev_out_valid`, it keeps that valid signal and the address or data steady until ready is seen. The only exception is a register write in that cycle (a reset or empty-buffer command, or a new pointer value). Memory returns `mem_rdata` and `mem_err` in the cycle it asserts `mem_req_ready`. The channel holds at most one word at a time, so memory and device transfers take turns.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset the status word reads 0, `irq` is low, no memory request or device-output valid is raised, and all pointers read 0.
- R2: Reading register address 0 returns the status flags at these positions: enable at bit 24, single-update at bit 25, device-to-memory direction at bit 26, complete at bit 27, bus exception at bit 28. All other bits read 0.
- R3: In a write to address 0, bit 16 sets enable and loads the direction from bit 18 (1 = device to memory, 0 = memory to device). Bit 17 sets single-update.
- R4: Command bit 20 clears enable, single-update, direction, complete and bus exception, and it empties the word buffer.
- R5: Command bit 21 empties the word buffer and leaves every status flag unchanged.
- R6: Pointer registers are at addresses 1 next, 2 limit, 3 second-start, 4 second-stop, and 5 to 8 hold the saved copies in that same order. Writes force next and second-start to 4-byte alignment (low 2 bits zero) and limit and second-stop to 16-byte alignment (low 4 bits zero). The saved copies are read-only.
- R7: Memory to device: the channel reads the word at next, presents it on the device output, and adds 4 to next for each word memory accepts. Words go out in address order.
- R8: Device to memory: the channel takes a word from the device input and writes it to memory at next, adding 4 to next when memory accepts the word.
- R9: When next reaches limit and single-update is set, complete is set, enable is cleared, and next is left equal to limit.
- R10: When next reaches limit and single-update is clear, limit is loaded from second-stop and next from second-start, complete is set, and the channel keeps running. In both R9 and R10 the saved bank receives the finished next, limit, second-start and second-stop.
- R11: An error response on an accepted memory request sets bus exception, clears enable, and leaves all pointers and the word buffer unchanged.
- R12: `irq` is high exactly while complete or bus exception is set.
- R13: Command bit 19 clears complete, but it has no effect in a cycle where the channel finishes a buffer.
- R14: A raised `mem_req_valid` or `dev_out_valid` stays high, with the same address or data, until it is accepted, unless a register write happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request and returns a response |
| mem_req_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | AW | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_req_ready` |
| mem_err | input | 1 | Error response, valid with `mem_req_ready` |
| dev_out_valid | output | 1 | Word for the device is valid |
| dev_out_ready | input | 1 | Device takes the word |
| dev_out_data | output | 32 | Word for the device |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_ready | output | 1 | Channel can take the word |
| dev_in_data | input | 32 | Word from the device |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with a 16-bit address width and the default 4-byte start and 16-byte end alignment. The narrow pointers let a 256-word memory model cover every buffer, and four-word buffers make finishing, chaining and error freezing visible within a few dozen cycles. The bench controls memory readiness and device readiness directly. This makes it possible to hold a request pending, to fill the word buffer and then empty it by command, and to land a clear-complete command on the very edge where a buffer finishes.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;
  localparam int WORD_W = 32;
  localparam int NPTR   = 4;

  // Working pointer slots
  localparam int P_NEXT  = 0;
  localparam int P_LIMIT = 1;
  localparam int P_START = 2;
  localparam int P_STOP  = 3;

  // Register addresses
  localparam logic [3:0] RA_CSR    = 4'd0;
  localparam logic [3:0] RA_PTR0   = 4'd1;
  localparam logic [3:0] RA_SAVED0 = 4'd5;

  // Status read-back bit positions
  localparam int ST_ENABLE = 24;
  localparam int ST_SUPD   = 25;
  localparam int ST_DIR    = 26;
  localparam int ST_DONE   = 27;
  localparam int ST_BERR   = 28;

  // Command bit positions
  localparam int CM_SETEN   = 16;
  localparam int CM_SETSU   = 17;
  localparam int CM_DIRRD   = 18;
  localparam int CM_CLRDONE = 19;
  localparam int CM_RESET   = 20;
  localparam int CM_INITBUF = 21;

  typedef struct packed {
    logic berr;
    logic done;
    logic dir_rd;
    logic supd;
    logic enable;
  } chan_status_t;
endpackage

// File: rtl/dma_chan_ctl.sv
`timescale 1ns/1ps
module dma_chan_ctl
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [WORD_W-1:0] cmd,
  input  logic              seg_done,
  input  logic              bus_err,
  output chan_status_t      st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      if (cmd_we) begin
        if (cmd[CM_RESET]) st <= '0;
        if (cmd[CM_SETEN]) begin
          st.enable <= 1'b1;
          st.dir_rd <= cmd[CM_DIRRD];
        end
        if (cmd[CM_SETSU]) st.supd <= 1'b1;
        if (cmd[CM_CLRDONE]) st.done <= 1'b0;
      end
      // Hardware events come last so they win over commands in the same cycle
      if (seg_done) begin
        st.done <= 1'b1;
        if (st.supd) st.enable <= 1'b0;
      end
      if (bus_err) begin
        st.berr   <= 1'b1;
        st.enable <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_ptr_bank.sv
`timescale 1ns/1ps
module dma_ptr_bank
  import dma_chain_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BEGIN_ALIGN = 4,
  parameter int END_ALIGN   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPTR-1:0] sw_we,
  input  logic [AW-1:0]   sw_data,
  input  logic            adv,
  input  logic            supd,
  output logic [AW-1:0]   work_q  [NPTR],
  output logic [AW-1:0]   saved_q [NPTR],
  output logic            seg_done,
  output logic            at_limit
);
  localparam int WORD_BYTES = WORD_W / 8;

  logic [AW-1:0] wmask [NPTR];
  logic [AW-1:0] next_inc;

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_mask
    if (gi == P_NEXT || gi == P_START) begin : g_begin
      assign wmask[gi] = ~AW'(BEGIN_ALIGN - 1);
    end else begin : g_end
      assign wmask[gi] = ~AW'(END_ALIGN - 1);
    end
  end

  assign next_inc = work_q[P_NEXT] + AW'(WORD_BYTES);
  assign seg_done = adv && (next_inc == work_q[P_LIMIT]);
  assign at_limit = (work_q[P_NEXT] == work_q[P_LIMIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPTR; i++) begin
        work_q[i]  <= '0;
        saved_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NPTR; i++)
        if (sw_we[i]) work_q[i] <= sw_data & wmask[i];
      if (adv) begin
        if (seg_done) begin
          saved_q[P_NEXT]  <= next_inc;
          saved_q[P_LIMIT] <= work_q[P_LIMIT];
          saved_q[P_START] <= work_q[P_START];
          saved_q[P_STOP]  <= work_q[P_STOP];
          if (supd) begin
            work_q[P_NEXT] <= next_inc;
          end else begin
            work_q[P_NEXT]  <= work_q[P_START];
            work_q[P_LIMIT] <= work_q[P_STOP];
          end
        end else begin
          work_q[P_NEXT] <= next_inc;
        end
      end
    end
  end
endmodule

// File: rtl/dma_word_mover.sv
`timescale 1ns/1ps
module dma_word_mover
  import dma_chain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              dir_rd,
  input  logic              at_limit,
  input  logic [AW-1:0]     next_ptr,
  input  logic              flush,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [WORD_W-1:0] dev_out_data,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [WORD_W-1:0] dev_in_data,
  output logic              adv,
  output logic              bus_err
);
  logic              buf_full;
  logic [WORD_W-1:0] buf_data;
  logic              mem_fire, run;

  assign run           = enable && !at_limit;
  assign mem_req_valid = run && (dir_rd ? buf_full : !buf_full);
  assign mem_req_we    = dir_rd;
  assign mem_req_addr  = next_ptr;
  assign mem_req_wdata = buf_data;
  assign mem_fire      = mem_req_valid && mem_req_ready;
  assign bus_err       = mem_fire && mem_err;
  assign adv           = mem_fire && !mem_err;

  assign dev_out_valid = !dir_rd && buf_full;
  assign dev_out_data  = buf_data;
  assign dev_in_ready  = dir_rd && run && !buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_data <= '0;
    end else if (flush) begin
      buf_full <= 1'b0;
    end else begin
      if (adv) begin
        if (dir_rd) begin
          buf_full <= 1'b0;
        end else begin
          buf_full <= 1'b1;
          buf_data <= mem_rdata;
        end
      end
      if (dev_out_valid && dev_out_ready) buf_full <= 1'b0;
      if (dev_in_valid && dev_in_ready) begin
        buf_full <= 1'b1;
        buf_data <= dev_in_data;
      end
    end
  end
endmodule

// File: rtl/dma_chain_channel.sv
`timescale 1ns/1ps
module dma_chain_channel
  import dma_chain_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BEGIN_ALIGN = 4,
  parameter int END_ALIGN   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [31:0]       dev_out_data,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [31:0]       dev_in_data,
  output logic              irq
);
  chan_status_t    st;
  logic            cmd_we, flush, seg_done, bus_err, adv, at_limit;
  logic [NPTR-1:0] ptr_we;
  logic [AW-1:0]   work_q  [NPTR];
  logic [AW-1:0]   saved_q [NPTR];

  assign cmd_we = reg_we && (reg_addr == RA_CSR);
  assign flush  = cmd_we && (reg_wdata[CM_INITBUF] || reg_wdata[CM_RESET]);

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_we
    assign ptr_we[gi] = reg_we && (reg_addr == RA_PTR0 + 4'(gi));
  end

  dma_chan_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(reg_wdata),
    .seg_done(seg_done), .bus_err(bus_err), .st(st)
  );

  dma_ptr_bank #(.AW(AW), .BEGIN_ALIGN(BEGIN_ALIGN), .END_ALIGN(END_ALIGN)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sw_we(ptr_we), .sw_data(reg_wdata[AW-1:0]),
    .adv(adv), .supd(st.supd), .work_q(work_q), .saved_q(saved_q),
    .seg_done(seg_done), .at_limit(at_limit)
  );

  dma_word_mover #(.AW(AW)) u_mov (
    .clk(clk), .rst_n(rst_n), .enable(st.enable), .dir_rd(st.dir_rd),
    .at_limit(at_limit), .next_ptr(work_q[P_NEXT]), .flush(flush),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
    .dev_out_data(dev_out_data), .dev_in_valid(dev_in_valid),
    .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
    .adv(adv), .bus_err(bus_err)
  );

  assign irq = st.done || st.berr;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_CSR) begin
      reg_rdata[ST_ENABLE] = st.enable;
      reg_rdata[ST_SUPD]   = st.supd;
      reg_rdata[ST_DIR]    = st.dir_rd;
      reg_rdata[ST_DONE]   = st.done;
      reg_rdata[ST_BERR]   = st.berr;
    end
    for (int i = 0; i < NPTR; i++) begin
      if (reg_addr == RA_PTR0 + 4'(i))   reg_rdata = 32'(work_q[i]);
      if (reg_addr == RA_SAVED0 + 4'(i)) reg_rdata = 32'(saved_q[i]);
    end
  end
endmodule

// File: rtl/dma_chain_channel_chk.sv
`timescale 1ns/1ps
module dma_chain_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_err,
  input logic          dev_out_valid,
  input logic          dev_out_ready,
  input logic [31:0]   dev_out_data,
  input logic          irq
);
  p_mem_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !reg_we |=> mem_req_valid && $stable(mem_req_addr));

  p_dev_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready && !reg_we |=> dev_out_valid && $stable(dev_out_data));

  p_err_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_err |=> !mem_req_valid && irq);

  p_addr_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  p_irq_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !reg_we |=> irq);
endmodule

bind dma_chain_channel dma_chain_channel_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_dma_chain_channel.sv
`timescale 1ns/1ps
module test_dma_chain_channel;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_req_we, mem_err;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rdata;
  logic dev_out_valid, dev_out_ready = 1'b1, dev_in_valid = 1'b0, dev_in_ready;
  logic [31:0] dev_out_data, dev_in_data;
  logic irq;

  always #10 clk = ~clk;

  dma_chain_channel #(.AW(AW)) i_dma_chain_channel (.*);

  // Memory, device sink and device source models
  logic [31:0] mem [256];
  logic [31:0] rx  [64];
  int rx_cnt = 0, src_cnt = 0;
  logic err_en = 1'b0;
  logic [AW-1:0] err_addr = '0;

  assign mem_rdata   = mem[mem_req_addr[9:2]];
  assign mem_err     = err_en && (mem_req_addr == err_addr);
  assign dev_in_data = 32'hA000 + 32'(src_cnt);

  initial for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 + 32'(i);

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready && mem_req_we && !mem_err)
      mem[mem_req_addr[9:2]] <= mem_req_wdata;
    if (dev_out_valid && dev_out_ready) begin
      rx[rx_cnt] <= dev_out_data;
      rx_cnt <= rx_cnt + 1;
    end
    if (dev_in_valid && dev_in_ready) src_cnt <= src_cnt + 1;
  end

  int tests = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
    if (!irq) chk({tag, " irq timeout"}, 32'(irq), 32'd1);
  endtask

  // Register vector table: address, write data, expected read-back (R6)
  localparam logic [67:0] VECS [6] = '{
    {4'd1, 32'h0000_1237, 32'h0000_1234},
    {4'd2, 32'h0000_1237, 32'h0000_1230},
    {4'd3, 32'h0000_00FF, 32'h0000_00FC},
    {4'd4, 32'h0000_00FF, 32'h0000_00F0},
    {4'd5, 32'h0000_5555, 32'h0000_0000},
    {4'd7, 32'h0000_AAAA, 32'h0000_0000}
  };

  localparam logic [31:0] C_EN = 32'h0001_0000, C_SU = 32'h0002_0000,
    C_RD = 32'h0004_0000, C_CLR = 32'h0008_0000, C_RST = 32'h0010_0000,
    C_INIT = 32'h0020_0000;

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 mem valid", 32'(mem_req_valid), 32'd0);
    rd(4'd1, d); chk("R1 next", d, 32'h0);

    // R6 vector table
    foreach (VECS[i]) begin
      wr(VECS[i][67:64], VECS[i][63:32]);
      rd(VECS[i][67:64], d);
      chk("R6 align/readonly", d, VECS[i][31:0]);
    end

    // R7 R9 R2 R3: memory to device, single update
    wr(4'd1, 32'h10); wr(4'd2, 32'h20); wr(4'd3, 32'h0); wr(4'd4, 32'h0);
    wr(4'd0, C_EN | C_SU);
    rd(4'd0, d); chk("R3 enable+supd bits 24/25", d, 32'h0300_0000);
    wait_irq("R9");
    repeat (3) @(negedge clk);
    chk("R7 word count", 32'(rx_cnt), 32'd4);
    for (int k = 0; k < 4; k++) chk("R7 word order", rx[k], 32'hC0DE0004 + 32'(k));
    rd(4'd0, d); chk("R9 R2 status done+supd", d, 32'h0A00_0000);
    rd(4'd1, d); chk("R9 next at limit", d, 32'h20);
    rd(4'd5, d); chk("R9 saved next", d, 32'h20);
    chk("R12 irq on complete", 32'(irq), 32'd1);
    wr(4'd0, C_RST);
    rd(4'd0, d); chk("R4 reset clears status", d, 32'h0);
    chk("R12 irq low after reset", 32'(irq), 32'd0);

    // R10: chain into second buffer
    wr(4'd1, 32'h40); wr(4'd2, 32'h50); wr(4'd3, 32'h80); wr(4'd4, 32'h90);
    wr(4'd0, C_EN);
    wait_irq("R10");
    rd(4'd2, d); chk("R10 limit reloaded", d, 32'h90);
    wr(4'd0, C_SU);
    rd(4'd6, d); chk("R10 saved limit", d, 32'h50);
    begin
      int n = 0;
      d = 32'hFFFF_FFFF;
      while (d[24] && n < 100) begin rd(4'd0, d); n++; end
    end
    repeat (2) @(negedge clk);
    chk("R10 word count", 32'(rx_cnt), 32'd12);
    for (int k = 0; k < 4; k++) begin
      chk("R10 first buffer", rx[4 + k], 32'hC0DE0010 + 32'(k));
      chk("R10 second buffer", rx[8 + k], 32'hC0DE0020 + 32'(k));
    end
    rd(4'd7, d); chk("R10 saved start", d, 32'h80);
    wr(4'd0, C_CLR);
    rd(4'd0, d); chk("R13 clear complete", d, 32'h0200_0000);
    chk("R12 irq low after clear", 32'(irq), 32'd0);
    wr(4'd0, C_RST);

    // R8: device to memory
    wr(4'd1, 32'hC0); wr(4'd2, 32'hD0);
    dev_in_valid = 1'b1;
    wr(4'd0, C_EN | C_SU | C_RD);
    wait_irq("R8");
    dev_in_valid = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) chk("R8 memory data", mem[48 + k], 32'hA000 + 32'(k));
    rd(4'd0, d); chk("R8 R3 status with direction bit 26", d, 32'h0E00_0000);
    wr(4'd0, C_RST);
    rd(4'd0, d); chk("R4 direction cleared", d, 32'h0);

    // R11: bus error
    err_addr = 16'h108; err_en = 1'b1;
    wr(4'd1, 32'h100); wr(4'd2, 32'h120);
    wr(4'd0, C_EN | C_SU);
    wait_irq("R11");
    @(negedge clk);
    err_en = 1'b0;
    rd(4'd0, d); chk("R11 status berr", d, 32'h1200_0000);
    rd(4'd1, d); chk("R11 next frozen", d, 32'h108);
    chk("R11 words before error", 32'(rx_cnt), 32'd14);
    chk("R11 no request", 32'(mem_req_valid), 32'd0);
    wr(4'd0, C_RST);
    chk("R12 irq low after berr reset", 32'(irq), 32'd0);

    // R5: empty the word buffer
    dev_out_ready = 1'b0;
    wr(4'd1, 32'h140); wr(4'd2, 32'h150);
    wr(4'd0, C_EN | C_SU);
    begin
      int n = 0;
      while (!dev_out_valid && n < 50) begin @(negedge clk); n++; end
    end
    chk("R5 buffer filled", dev_out_data, 32'hC0DE0050);
    wr(4'd0, C_INIT);
    chk("R5 buffer emptied", 32'(dev_out_valid), 32'd0);
    rd(4'd0, d); chk("R5 status unchanged", d, 32'h0300_0000);
    wr(4'd0, C_RST);
    @(negedge clk);
    chk("R4 buffer emptied by reset", 32'(dev_out_valid), 32'd0);
    dev_out_ready = 1'b1;

    // R14 and R13: pending request, then clear-complete on the finishing edge
    mem_req_ready = 1'b0;
    wr(4'd1, 32'h14C); wr(4'd2, 32'h150);
    wr(4'd0, C_EN | C_SU);
    wr(4'd0, C_EN | C_SU);  // complete is still 0; sets nothing new
    repeat (3) @(negedge clk);
    chk("R14 request held", 32'(mem_req_valid), 32'd1);
    chk("R14 address held", 32'(mem_req_addr), 32'h14C);
    @(negedge clk);
    // put complete at 1 first via a different path: not available, so the
    // collision check below relies on the finish setting it
    mem_req_ready = 1'b1;
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = C_CLR;
    @(negedge clk);
    reg_we = 1'b0;
    rd(4'd0, d); chk("R13 clear ignored while finishing", d, 32'h0A00_0000);
    repeat (2) @(negedge clk);
    chk("R7 single word delivered", rx[14], 32'hC0DE0053);
    wr(4'd0, C_CLR);
    rd(4'd0, d); chk("R13 clear after finish", d, 32'h0200_0000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule